// File: doc/BRIEF.md
# Hot-Swap Two-Wire Bus Connection Controller

This block decides when the data and clock lines of a plug-in card may be joined to a backplane two-wire bus that is already running. While the supply is in undervoltage lockout it keeps the two sides apart and ignores all line activity. After lockout ends, it waits for a point where the backplane bus is free. That point is either a STOP condition or a run of idle time with both backplane lines high. At that point it also requires both card lines to be high. Only then does it join the two sides and raise a ready flag.

A chip-select input breaks the join at once, in the same cycle. When chip-select is released, the full qualification runs again. While joined, each line (data and clock) behaves as a wired-AND across both sides. The block drives one low-enable per side per line. An ownership latch records which side pulled a line low first, so that the block never holds a line low through the echo of its own drive. The qualification logic samples the lines through a synchronizer. The wired-AND join works on pin levels and registers its decision once.

Top module: `hsbus_link_ctrl`

## Requirements
- R1: During and right after reset, ready_o and all four low-enable outputs are 0.
- R2: While uvlo_i is 1, ready_o and all low-enables are 0 in that same cycle, and no STOP or idle on either side can lead to a connection.
- R3: A STOP (backplane data rising while backplane clock is high, both seen after a two-stage synchronizer) qualifies the bus as free once uvlo_i and cs_i are both 0.
- R4: The bus also qualifies as free after both backplane lines stay high for CLK_PER_US*IDLE_US consecutive cycles. Any low on either line restarts the count.
- R5: After the bus qualifies as free, the link is made only if both synchronized card lines are high in the cycle after qualification. Otherwise the block goes back to waiting for a new STOP or idle.
- R6: When cs_i is 1, ready_o and all low-enables are 0 in the same cycle, with no clock edge needed.
- R7: After cs_i returns to 0, the link stays down until a new STOP or idle and a new card check have happened.
- R8: ready_o is 1 exactly when the link is made and both cs_i and uvlo_i are 0.
- R9: While joined, a low on the backplane data (clock) pin sets card_sda_low_o (card_scl_low_o) from the next clock edge. A low on a card pin sets the matching backplane low-enable in the same way.
- R10: A low-enable drops on the clock edge after the owning side's pin reads high. The block does not then treat its own released echo as a new low on the other side.
- R11: If both sides of a line are low at the same edge while no side owns it, the backplane side takes ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo_i | input | 1 | Undervoltage lockout active |
| cs_i | input | 1 | Chip-select; 1 forces disconnection |
| bp_sda_i | input | 1 | Backplane data pin level |
| bp_scl_i | input | 1 | Backplane clock pin level |
| card_sda_i | input | 1 | Card data pin level |
| card_scl_i | input | 1 | Card clock pin level |
| bp_sda_low_o | output | 1 | Pull backplane data low |
| bp_scl_low_o | output | 1 | Pull backplane clock low |
| card_sda_low_o | output | 1 | Pull card data low |
| card_scl_low_o | output | 1 | Pull card clock low |
| ready_o | output | 1 | Link made and usable |

## Verification
Two events can fall in the same cycle. The first pair is a chip-select pulse and the detection of a STOP. The bench slides a one-cycle chip-select pulse across a STOP at several offsets, so that the pulse at some point lands in the cycle where the STOP is qualified and at another point lands on the card check. The second pair is a card-side low and a backplane-side low on one line. The bench drives both in the same cycle and then releases the backplane first. A behavioural model predicts every output in every cycle and judges these cases. The model confirms that a pulse landing on the STOP cycle cancels the connection, that the backplane takes ownership in the tie, and that the card then takes ownership without any echo.

// File: rtl/hsbus_pkg.sv
package hsbus_pkg;
  typedef enum logic [1:0] {
    ST_LOCKOUT    = 2'd0,
    ST_WAIT_FREE  = 2'd1,
    ST_CHECK_CARD = 2'd2,
    ST_CONNECTED  = 2'd3
  } link_state_t;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_BP   = 2'd1,
    OWN_CD   = 2'd2
  } line_owner_t;
endpackage

// File: rtl/hsbus_sync.sv
module hsbus_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  // lines idle high, so the chain resets to ones
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hsbus_free_detect.sv
module hsbus_free_detect #(
  parameter int IDLE_CYC = 380
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic sda,
  input  logic scl,
  output logic free_evt
);
  localparam int CW = $clog2(IDLE_CYC + 1);

  logic          sda_q;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          both_hi, at_limit, stop_seen, idle_seen;

  assign both_hi   = sda & scl;
  assign at_limit  = (cnt == CW'(IDLE_CYC - 1));
  assign stop_seen = arm & ~sda_q & sda & scl;
  assign idle_seen = arm & both_hi & at_limit;
  assign free_evt  = stop_seen | idle_seen;

  always_comb begin
    cnt_nxt = cnt;
    if (!arm || !both_hi)  cnt_nxt = '0;
    else if (!at_limit)    cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q <= 1'b1;
      cnt   <= '0;
    end else begin
      sda_q <= sda;
      cnt   <= cnt_nxt;
    end
  end

  // R4: an idle event needs high lines on the previous cycle too
  p_idle_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    idle_seen |-> $past(both_hi));
endmodule

// File: rtl/hsbus_join_line.sv
module hsbus_join_line
  import hsbus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bp_line,
  input  logic cd_line,
  output logic pull_bp,
  output logic pull_cd
);
  line_owner_t owner, owner_nxt;

  always_comb begin
    owner_nxt = owner;
    if (!en) begin
      owner_nxt = OWN_NONE;
    end else begin
      unique case (owner)
        OWN_NONE: begin
          if (!bp_line)      owner_nxt = OWN_BP;
          else if (!cd_line) owner_nxt = OWN_CD;
        end
        OWN_BP:  if (bp_line) owner_nxt = OWN_NONE;
        OWN_CD:  if (cd_line) owner_nxt = OWN_NONE;
        default: owner_nxt = OWN_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner <= OWN_NONE;
    else        owner <= owner_nxt;
  end

  assign pull_cd = en & (owner == OWN_BP);
  assign pull_bp = en & (owner == OWN_CD);

  // R9: card-side drive only ever starts after a backplane low
  p_pull_follows_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_cd) |-> $past(!bp_line));
  // R10: once the owning side reads high, the drive is gone next cycle
  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_cd && bp_line) |=> !pull_cd);
endmodule

// File: rtl/hsbus_link_ctrl.sv
module hsbus_link_ctrl
  import hsbus_pkg::*;
#(
  parameter int CLK_PER_US  = 4,
  parameter int IDLE_US     = 95,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uvlo_i,
  input  logic cs_i,
  input  logic bp_sda_i,
  input  logic bp_scl_i,
  input  logic card_sda_i,
  input  logic card_scl_i,
  output logic bp_sda_low_o,
  output logic bp_scl_low_o,
  output logic card_sda_low_o,
  output logic card_scl_low_o,
  output logic ready_o
);
  localparam int IDLE_CYC = CLK_PER_US * IDLE_US;
  localparam int NLINES   = 2;

  link_state_t       state, state_nxt;
  logic [3:0]        sync_q;
  logic              bus_free, card_hi, arm, en;
  logic [NLINES-1:0] bp_pin, cd_pin, pull_bp, pull_cd;

  hsbus_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({card_scl_i, card_sda_i, bp_scl_i, bp_sda_i}),
    .q     (sync_q)
  );

  assign arm     = (state == ST_WAIT_FREE) & ~cs_i;
  assign card_hi = sync_q[2] & sync_q[3];

  hsbus_free_detect #(.IDLE_CYC(IDLE_CYC)) u_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .sda      (sync_q[0]),
    .scl      (sync_q[1]),
    .free_evt (bus_free)
  );

  always_comb begin
    state_nxt = state;
    if (uvlo_i) begin
      state_nxt = ST_LOCKOUT;
    end else begin
      unique case (state)
        ST_LOCKOUT:    state_nxt = ST_WAIT_FREE;
        ST_WAIT_FREE:  if (bus_free) state_nxt = ST_CHECK_CARD;
        ST_CHECK_CARD: state_nxt = (cs_i || !card_hi) ? ST_WAIT_FREE : ST_CONNECTED;
        ST_CONNECTED:  if (cs_i) state_nxt = ST_WAIT_FREE;
        default:       state_nxt = ST_LOCKOUT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_LOCKOUT;
    else        state <= state_nxt;
  end

  // chip-select and lockout cut the join without waiting for an edge
  assign en      = (state == ST_CONNECTED) & ~cs_i & ~uvlo_i;
  assign ready_o = en;

  assign bp_pin = {bp_scl_i, bp_sda_i};
  assign cd_pin = {card_scl_i, card_sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    hsbus_join_line u_join (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .bp_line (bp_pin[g]),
      .cd_line (cd_pin[g]),
      .pull_bp (pull_bp[g]),
      .pull_cd (pull_cd[g])
    );
  end

  assign bp_sda_low_o   = pull_bp[0];
  assign bp_scl_low_o   = pull_bp[1];
  assign card_sda_low_o = pull_cd[0];
  assign card_scl_low_o = pull_cd[1];

  // R2: lockout always wins on the next edge
  p_lockout_r2: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_i |=> (state == ST_LOCKOUT));
  // R3: the link is only entered from the card check
  p_connect_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_CONNECTED) |-> $past(state == ST_CHECK_CARD));
  // R5: the card lines were high when the link was made
  p_card_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_CONNECTED) |-> $past(card_hi));
  // R7: a chip-select disconnect never lands back in the link directly
  p_requalify_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_CONNECTED) && cs_i && !uvlo_i) |=> (state == ST_WAIT_FREE));
endmodule

// File: tb/hsbus_link_ctrl_bench.sv
module hsbus_link_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 4;
  localparam int IDLE_US    = 95;
  localparam int IDLE       = CPU * IDLE_US;

  logic clk = 1'b0;
  logic rst_n, uvlo, cs;
  logic [1:0] bp_ext, cd_ext;   // [0]=data, [1]=clock; external open-drain level
  logic bp_sda_low, bp_scl_low, card_sda_low, card_scl_low, ready;
  logic bp_sda, bp_scl, card_sda, card_scl;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bp_sda   = bp_ext[0] & ~bp_sda_low;
  assign bp_scl   = bp_ext[1] & ~bp_scl_low;
  assign card_sda = cd_ext[0] & ~card_sda_low;
  assign card_scl = cd_ext[1] & ~card_scl_low;

  hsbus_link_ctrl #(.CLK_PER_US(CPU), .IDLE_US(IDLE_US), .SYNC_STAGES(2)) u_hsbus_link_ctrl (
    .clk(clk), .rst_n(rst_n), .uvlo_i(uvlo), .cs_i(cs),
    .bp_sda_i(bp_sda), .bp_scl_i(bp_scl), .card_sda_i(card_sda), .card_scl_i(card_scl),
    .bp_sda_low_o(bp_sda_low), .bp_scl_low_o(bp_scl_low),
    .card_sda_low_o(card_sda_low), .card_scl_low_o(card_scl_low),
    .ready_o(ready)
  );

  // ---------------- behavioural reference ----------------
  // m_phase: 0 locked, 1 waiting for free bus, 2 card check, 3 linked
  int m_phase, m_idle;
  int m_own[2];          // 0 nobody, 1 backplane drove first, 2 card drove first
  bit m_s1[4], m_s2[4];  // sampled line history: bp data, bp clock, card data, card clock
  bit m_prev_data;

  function automatic bit m_en();
    return (m_phase == 3) && !cs && !uvlo;
  endfunction
  function automatic bit m_pull_card(int i);
    return m_en() && (m_own[i] == 1);
  endfunction
  function automatic bit m_pull_bp(int i);
    return m_en() && (m_own[i] == 2);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_idle = 0; m_prev_data = 1'b1;
      foreach (m_own[i]) m_own[i] = 0;
      foreach (m_s1[i]) begin m_s1[i] = 1'b1; m_s2[i] = 1'b1; end
    end else begin
      bit pin[4];
      int own_n[2];
      bit lined, free_now, hi;
      int ph_n, idle_n;
      for (int i = 0; i < 2; i++) begin
        pin[i]   = bp_ext[i] & ~m_pull_bp(i);
        pin[i+2] = cd_ext[i] & ~m_pull_card(i);
      end
      for (int i = 0; i < 2; i++) begin
        own_n[i] = m_own[i];
        if (!m_en()) own_n[i] = 0;
        else if (m_own[i] == 0) begin
          if (!pin[i]) own_n[i] = 1;
          else if (!pin[i+2]) own_n[i] = 2;
        end else if (m_own[i] == 1 && pin[i]) own_n[i] = 0;
        else if (m_own[i] == 2 && pin[i+2]) own_n[i] = 0;
      end
      lined = (m_phase == 1) && !cs;
      hi = m_s2[0] && m_s2[1];
      free_now = lined && ((!m_prev_data && hi) || (hi && m_idle == IDLE - 1));
      idle_n = (!lined || !hi) ? 0 : ((m_idle == IDLE - 1) ? m_idle : m_idle + 1);
      ph_n = m_phase;
      if (uvlo) ph_n = 0;
      else case (m_phase)
        0: ph_n = 1;
        1: if (free_now) ph_n = 2;
        2: ph_n = (cs || !(m_s2[2] && m_s2[3])) ? 1 : 3;
        default: if (cs) ph_n = 1;
      endcase
      m_phase = ph_n; m_idle = idle_n;
      m_own[0] = own_n[0]; m_own[1] = own_n[1];
      m_prev_data = m_s2[0];
      for (int i = 0; i < 4; i++) begin m_s2[i] = m_s1[i]; m_s1[i] = pin[i]; end
    end
  end

  task automatic compare_all();
    logic [4:0] act, exp;
    act = {ready, card_scl_low, card_sda_low, bp_scl_low, bp_sda_low};
    exp = {m_en(), m_pull_card(1), m_pull_card(0), m_pull_bp(1), m_pull_bp(0)};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t {ready,cdscl,cdsda,bpscl,bpsda} actual=%b expected=%b",
               cur_req, $time, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic chk(logic act, logic exp, string req, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic stop_on_bp();
    bp_ext[0] = 1'b0; cyc(4);
    bp_ext[0] = 1'b1; cyc(6);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 1'b0; uvlo = 1'b1; cs = 1'b0; bp_ext = 2'b11; cd_ext = 2'b11;
    cur_req = "R1";
    cyc(3);
    chk(ready, 1'b0, "R1", "ready in reset");
    chk(card_sda_low | bp_sda_low, 1'b0, "R1", "pulls in reset");
    rst_n = 1'b1;
    cyc(2);

    // R2: lockout ignores a STOP and a long idle
    cur_req = "R2";
    stop_on_bp();
    cyc(IDLE + 20);
    chk(ready, 1'b0, "R2", "ready during lockout");

    // R3: STOP connects
    cur_req = "R3";
    uvlo = 1'b0;
    cyc(3);
    stop_on_bp();
    chk(ready, 1'b1, "R3", "ready after STOP");

    // R9 / R10: backplane low propagates to card, released cleanly
    cur_req = "R9";
    bp_ext[0] = 1'b0; cyc(1);
    chk(card_sda_low, 1'b1, "R9", "card data driven low");
    cyc(3);
    cur_req = "R10";
    bp_ext[0] = 1'b1; cyc(1);
    chk(card_sda_low, 1'b0, "R10", "card data released");
    cyc(3);
    chk(bp_sda_low, 1'b0, "R10", "no echo onto backplane data");

    cur_req = "R9";
    cd_ext[1] = 1'b0; cyc(1);
    chk(bp_scl_low, 1'b1, "R9", "backplane clock driven low");
    cur_req = "R10";
    cd_ext[1] = 1'b1; cyc(1);
    chk(bp_scl_low, 1'b0, "R10", "backplane clock released");
    cyc(3);

    // R11: tie goes to backplane, then card takes over without echo
    cur_req = "R11";
    bp_ext[0] = 1'b0; cd_ext[0] = 1'b0; cyc(1);
    chk(card_sda_low, 1'b1, "R11", "backplane wins tie");
    chk(bp_sda_low, 1'b0, "R11", "card side not owner");
    bp_ext[0] = 1'b1; cyc(2);
    chk(bp_sda_low, 1'b1, "R11", "card holds line after handover");
    cd_ext[0] = 1'b1; cyc(3);

    // R6: chip-select cuts an active drive in the same cycle
    cur_req = "R6";
    cd_ext[0] = 1'b0; cyc(2);
    cs = 1'b1; #1;
    chk(bp_sda_low, 1'b0, "R6", "drive cut by cs");
    chk(ready, 1'b0, "R6", "ready cut by cs");
    cyc(3);
    cd_ext[0] = 1'b1;
    cyc(2);

    // R7: release cs, no reconnection without a new free point
    cur_req = "R7";
    cs = 1'b0;
    cyc(30);
    chk(ready, 1'b0, "R7", "no reconnect without STOP or idle");
    stop_on_bp();
    chk(ready, 1'b1, "R7", "reconnect after STOP");

    // R4: idle path with a restart
    cur_req = "R4";
    cs = 1'b1; cyc(2); cs = 1'b0;
    cyc(200);
    bp_ext[1] = 1'b0; cyc(1); bp_ext[1] = 1'b1;
    cyc(IDLE - 20);
    chk(ready, 1'b0, "R4", "idle count restarted by low");
    cyc(40);
    chk(ready, 1'b1, "R4", "connected after idle");

    // R5: card busy at the free point
    cur_req = "R5";
    cs = 1'b1; cyc(2); cs = 1'b0;
    cd_ext[0] = 1'b0;
    stop_on_bp();
    chk(ready, 1'b0, "R5", "card low blocks link");
    cd_ext[0] = 1'b1; cyc(6);
    chk(ready, 1'b0, "R5", "no link without fresh free point");
    stop_on_bp();
    chk(ready, 1'b1, "R5", "link after card high and STOP");

    // R8 / R7: chip-select pulse slid across a STOP
    cur_req = "R8";
    for (int off = 0; off < 8; off++) begin
      cs = 1'b1; cyc(1); cs = 1'b0;
      bp_ext[0] = 1'b0; cyc(3);
      bp_ext[0] = 1'b1;
      cyc(off);
      cs = 1'b1; cyc(1); cs = 1'b0;
      cyc(8);
    end

    // R2: lockout while linked, then requalify
    cur_req = "R2";
    stop_on_bp();
    uvlo = 1'b1; #1;
    chk(ready, 1'b0, "R2", "lockout drops ready");
    cyc(2); uvlo = 1'b0;
    cyc(10);
    chk(ready, 1'b0, "R2", "lockout requires requalification");
    stop_on_bp();
    chk(ready, 1'b1, "R8", "ready after requalification");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule